// File: doc/BRIEF.md
# Complex-Coefficient Baseband FIR Filter

This block is a 64-tap FIR filter for sideband suppression at baseband. Real input samples enter a single delay line. Each stored sample is multiplied by a complex coefficient, which has a real part and an imaginary part. Two parallel sums run over the same taps, so one shared data path gives both the real and the imaginary output. No second real filter is needed.

All ports use one number format: signed 16-bit fixed point with two integer bits and fourteen fraction bits (Q2.14). The sums are kept at full precision until the last stage. That stage rounds them back to Q2.14 and clips any value out of range. After reset the coefficient set makes the block a plain real pass-through. Software, or a neighbouring block, can rewrite any coefficient through the write port at any time. The block accepts one sample every clock cycle. It gives one complex result per accepted sample, after a fixed delay.

Top module: `cfir_baseband`

## Requirements
- R1: While reset is held and directly after it, out_valid is 0 and both output words are 0. Reset clears every delay-line entry to 0. Reset loads the default coefficients: real part of tap 0 = 0x4000 (1.0), every other real part and every imaginary part = 0.
- R2: The delay line moves only in a cycle with in_valid high. Tap k then holds the k-th most recent accepted sample, with tap 0 the newest. In a cycle with in_valid low, no stored sample changes.
- R3: The real output is the requantised value of the sum over k of tap[k] times the real part of coefficient k.
- R4: The imaginary output is the requantised value of the sum over k of tap[k] times the imaginary part of coefficient k. It uses the same delay line as R3.
- R5: Each cycle with in_valid high gives exactly one out_valid pulse, 3 clock cycles after the edge that captured the sample. out_valid is never high at any other time.
- R6: A cycle with coef_we high writes coef_re and coef_im into tap coef_addr (0 = newest sample) and touches no other tap. The new value applies to every sample accepted in the same cycle or later.
- R7: Requantisation rounds half up: result = floor((S + 2^13) / 2^14). S is the exact sum in units of 2^-28.
- R8: A requantised value above 32767 gives 32767 (0x7FFF). A value below -32768 gives -32768 (0x8000). The sum is never clipped before the final stage.
- R9: Between out_valid pulses, out_re and out_im keep the last value they carried.
- R10: Samples sent on back-to-back cycles are all accepted, and their results come out on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is present this cycle |
| in_sample | input | 16 | Real input sample, Q2.14 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Tap index to write, 0 = newest sample |
| coef_re | input | 16 | Real part of the coefficient, Q2.14 |
| coef_im | input | 16 | Imaginary part of the coefficient, Q2.14 |
| out_valid | output | 1 | Result pulse, one per accepted sample |
| out_re | output | 16 | Real part of the result, Q2.14 |
| out_im | output | 16 | Imaginary part of the result, Q2.14 |

## Verification
The hardest cases to reach from the ports are the exact half-LSB ties in the rounder and sums that run past the 16-bit range. Random data almost never lands on a tie. The bench loads a single tap of +0.5 (real part) and -0.5 (imaginary part). It then sweeps every one of the 65,536 input codes. Every odd code then makes a tie, with opposite signs on the two outputs. For clipping, all taps get extreme coefficients and the bench streams full-scale runs. This drives the 38-bit sums far past the output range in both directions.

// File: rtl/cfir_pkg.sv
package cfir_pkg;
    localparam int CFIR_TAPS = 64;
    localparam int CFIR_DW   = 16;
    localparam int CFIR_FRAC = 14;

    // Accumulator width: full product plus growth for the tap count
    function automatic int cfir_acc_width(input int dw, input int taps);
        return 2 * dw + $clog2(taps);
    endfunction
endpackage

// File: rtl/cfir_delay_line.sv
module cfir_delay_line #(
    parameter int NTAPS = 64,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic [DW-1:0]              sample_in,
    output logic [NTAPS-1:0][DW-1:0]   taps
);
    typedef struct packed {
        logic [NTAPS-1:0][DW-1:0] line;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            for (int i = NTAPS - 1; i > 0; i--) begin
                st_d.line[i] = st_q.line[i-1];
            end
            st_d.line[0] = sample_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign taps = st_q.line;

    // R2
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps));
    // R2
    newest_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> taps[0] == $past(sample_in));
endmodule

// File: rtl/cfir_coef_bank.sv
module cfir_coef_bank #(
    parameter int NTAPS = 64,
    parameter int DW    = 16,
    parameter int FRAC  = 14,
    localparam int AW   = $clog2(NTAPS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wr_re,
    input  logic [DW-1:0]              wr_im,
    output logic [NTAPS-1:0][DW-1:0]   coef_re,
    output logic [NTAPS-1:0][DW-1:0]   coef_im
);
    localparam logic [DW-1:0] UNITY = {{(DW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

    typedef struct packed {
        logic [NTAPS-1:0][DW-1:0] re;
        logic [NTAPS-1:0][DW-1:0] im;
    } cb_state_t;

    cb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.re[addr] = wr_re;
            st_d.im[addr] = wr_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.re[0] <= UNITY;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef_re = st_q.re;
    assign coef_im = st_q.im;

    // R6
    coef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (coef_re[$past(addr)] == $past(wr_re)) && (coef_im[$past(addr)] == $past(wr_im)));
    // R6
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(coef_re) && $stable(coef_im));
endmodule

// File: rtl/cfir_dot.sv
module cfir_dot #(
    parameter int NTAPS = 64,
    parameter int DW    = 16,
    parameter int ACC_W = 38
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NTAPS-1:0][DW-1:0]   taps,
    input  logic [NTAPS-1:0][DW-1:0]   coefs,
    output logic [ACC_W-1:0]           acc
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [NTAPS-1:0][PW-1:0] prod;
        logic [ACC_W-1:0]         sum;
    } dot_state_t;

    dot_state_t st_d, st_q;

    always_comb begin
        logic signed [PW-1:0]    p;
        logic        [ACC_W-1:0] s;
        st_d = st_q;
        // stage 1: every tap product at full width
        for (int i = 0; i < NTAPS; i++) begin
            p = $signed(taps[i]) * $signed(coefs[i]);
            st_d.prod[i] = p;
        end
        // stage 2: sign-extended sum of the registered products
        s = '0;
        for (int i = 0; i < NTAPS; i++) begin
            s = s + {{(ACC_W-PW){st_q.prod[i][PW-1]}}, st_q.prod[i]};
        end
        st_d.sum = s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.sum;
endmodule

// File: rtl/cfir_requant.sv
module cfir_requant #(
    parameter int ACC_W = 38,
    parameter int DW    = 16,
    parameter int FRAC  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [ACC_W-1:0]  acc_re,
    input  logic [ACC_W-1:0]  acc_im,
    output logic              out_valid,
    output logic [DW-1:0]     out_re,
    output logic [DW-1:0]     out_im
);
    localparam logic signed [ACC_W:0] RND = {{(ACC_W+1-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [ACC_W:0] HI  = {{(ACC_W-DW+2){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W:0] LO  = {{(ACC_W-DW+2){1'b1}}, {(DW-1){1'b0}}};

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] re;
        logic [DW-1:0] im;
    } rq_state_t;

    rq_state_t st_d, st_q;

    function automatic logic [DW-1:0] squash(input logic [ACC_W-1:0] a);
        logic signed [ACC_W:0] w;
        w = $signed({a[ACC_W-1], a}) + RND;
        w = w >>> FRAC;
        if (w > HI)      return HI[DW-1:0];
        else if (w < LO) return LO[DW-1:0];
        else             return w[DW-1:0];
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_in;
        if (valid_in) begin
            st_d.re = squash(acc_re);
            st_d.im = squash(acc_im);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_re    = st_q.re;
    assign out_im    = st_q.im;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(out_re) && $stable(out_im));
endmodule

// File: rtl/cfir_baseband.sv
module cfir_baseband
    import cfir_pkg::*;
#(
    parameter int NTAPS = CFIR_TAPS,
    parameter int DW    = CFIR_DW,
    parameter int FRAC  = CFIR_FRAC,
    localparam int AW    = $clog2(NTAPS),
    localparam int ACC_W = cfir_acc_width(DW, NTAPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_sample,
    input  logic           coef_we,
    input  logic [AW-1:0]  coef_addr,
    input  logic [DW-1:0]  coef_re,
    input  logic [DW-1:0]  coef_im,
    output logic           out_valid,
    output logic [DW-1:0]  out_re,
    output logic [DW-1:0]  out_im
);
    localparam int NPART = 2;   // index 0 = real part, 1 = imaginary part

    typedef struct packed {
        logic [2:0] vpipe;      // taps, products, sums
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NTAPS-1:0][DW-1:0]             taps;
    logic [NPART-1:0][NTAPS-1:0][DW-1:0]  coef_parts;
    logic [NPART-1:0][ACC_W-1:0]          acc_parts;

    always_comb begin
        st_d       = st_q;
        st_d.vpipe = {st_q.vpipe[1:0], in_valid};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cfir_delay_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (in_valid),
        .sample_in (in_sample),
        .taps      (taps)
    );

    cfir_coef_bank #(.NTAPS(NTAPS), .DW(DW), .FRAC(FRAC)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (coef_we),
        .addr    (coef_addr),
        .wr_re   (coef_re),
        .wr_im   (coef_im),
        .coef_re (coef_parts[0]),
        .coef_im (coef_parts[1])
    );

    for (genvar p = 0; p < NPART; p++) begin : g_part
        cfir_dot #(.NTAPS(NTAPS), .DW(DW), .ACC_W(ACC_W)) u_dot (
            .clk   (clk),
            .rst_n (rst_n),
            .taps  (taps),
            .coefs (coef_parts[p]),
            .acc   (acc_parts[p])
        );
    end

    cfir_requant #(.ACC_W(ACC_W), .DW(DW), .FRAC(FRAC)) u_rq (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (st_q.vpipe[2]),
        .acc_re    (acc_parts[0]),
        .acc_im    (acc_parts[1]),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##3 out_valid);
    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4));
endmodule

// File: tb/tb_cfir_baseband.sv
module tb_cfir_baseband;
    localparam int PERIOD = 10;
    localparam int WD_CYCLES = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic coef_we = 1'b0;
    logic [5:0] coef_addr = '0;
    logic [15:0] coef_re = '0;
    logic [15:0] coef_im = '0;
    logic out_valid;
    logic [15:0] out_re, out_im;

    cfir_baseband dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_re(coef_re), .coef_im(coef_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    always #(PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // bench model
    longint hist [64];
    longint mre [64];
    longint mim [64];
    logic [15:0] q_re [4096];
    logic [15:0] q_im [4096];
    int q_due [4096];
    int qwr = 0;
    int qrd = 0;
    logic [15:0] last_re = '0;
    logic [15:0] last_im = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] rnd16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[31:16];
    endfunction

    function automatic logic [15:0] rq(input longint s);
        longint t;
        t = (s + 64'sd8192) >>> 14;           // R7 round half up
        if (t > 32767) t = 32767;              // R8 clip
        if (t < -32768) t = -32768;
        return 16'(t);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 64; k++) begin
            hist[k] = 0; mre[k] = 0; mim[k] = 0;
        end
        mre[0] = 16384;
        last_re = '0; last_im = '0;
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic drive(input bit v, input logic [15:0] x, input bit we,
                         input logic [5:0] a, input logic [15:0] cr, input logic [15:0] ci);
        longint sr, si;
        @(negedge clk);
        in_valid = v; in_sample = x; coef_we = we; coef_addr = a; coef_re = cr; coef_im = ci;
        if (we) begin
            mre[a] = longint'($signed(cr));
            mim[a] = longint'($signed(ci));
        end
        if (v) begin
            for (int k = 63; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(x));
            sr = 0; si = 0;
            for (int k = 0; k < 64; k++) begin
                sr += hist[k] * mre[k];
                si += hist[k] * mim[k];
            end
            q_re[qwr % 4096] = rq(sr);
            q_im[qwr % 4096] = rq(si);
            q_due[qwr % 4096] = cyc + 4;
            qwr++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, '0, '0, '0);
    endtask

    task automatic load_all(input int mode);
        logic [15:0] cr, ci;
        for (int a = 0; a < 64; a++) begin
            case (mode)
                0: begin cr = rnd16(); ci = rnd16(); end
                1: begin cr = (a == 0) ? 16'd8192 : 16'd0; ci = (a == 0) ? 16'hE000 : 16'd0; end
                default: begin cr = 16'h7FFF; ci = 16'h8000; end
            endcase
            drive(1'b0, '0, 1'b1, 6'(a), cr, ci);
        end
        idle(5);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0; coef_we = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1 outputs while reset is held
        check(out_valid == 1'b0, "R1 valid in reset", {15'd0, out_valid}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", {15'd0, out_valid}, 16'd0);
        check(out_re == 16'd0, "R1 out_re after reset", out_re, 16'd0);
        check(out_im == 16'd0, "R1 out_im after reset", out_im, 16'd0);
    endtask

    // monitor: R3 R4 R5 R9 R10
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (qrd == qwr || q_due[qrd % 4096] != cyc) begin
                    check(1'b0, "R5 unexpected out_valid", {15'd0, out_valid}, 16'd0);
                end else begin
                    check(out_re == q_re[qrd % 4096], "R3/R7/R8 real output", out_re, q_re[qrd % 4096]);
                    check(out_im == q_im[qrd % 4096], "R4/R7/R8 imaginary output", out_im, q_im[qrd % 4096]);
                    qrd++;
                end
                last_re = out_re; last_im = out_im;
            end else begin
                if (qrd != qwr && q_due[qrd % 4096] == cyc) begin
                    check(1'b0, "R5 missing out_valid", 16'd0, 16'd1);
                    qrd++;
                end
                check(out_re == last_re, "R9 out_re held", out_re, last_re);
                check(out_im == last_im, "R9 out_im held", out_im, last_im);
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R1 default coefficients: pass-through, R10 back-to-back stream
        for (int i = 0; i < 80; i++) drive(1'b1, rnd16(), 1'b0, '0, '0, '0);
        idle(6);

        // R1 delay line cleared by a second reset, then R6 loads and R2 gaps
        do_reset();
        load_all(0);
        for (int i = 0; i < 300; i++) begin
            logic [15:0] r;
            r = rnd16();
            drive(r[0], rnd16(), 1'b0, '0, '0, '0);
        end
        idle(6);

        // R6: single-tap rewrite in the same cycle as a sample
        drive(1'b1, 16'h1000, 1'b1, 6'd5, 16'h2000, 16'hF000);
        for (int i = 0; i < 70; i++) drive(1'b1, rnd16(), 1'b0, '0, '0, '0);
        idle(6);

        // R7 exhaustive input sweep with +0.5 / -0.5 single tap: ties on odd codes
        load_all(1);
        for (int x = -32768; x < 32768; x++) drive(1'b1, 16'(x), 1'b0, '0, '0, '0);
        idle(6);

        // R8 clipping: extreme coefficients with full-scale runs
        load_all(2);
        for (int i = 0; i < 70; i++) drive(1'b1, 16'h7FFF, 1'b0, '0, '0, '0);
        for (int i = 0; i < 70; i++) drive(1'b1, 16'h8000, 1'b0, '0, '0, '0);
        for (int i = 0; i < 70; i++) drive(1'b1, rnd16(), 1'b0, '0, '0, '0);
        idle(6);

        // R5: every accepted sample produced exactly one result
        check(qrd == qwr, "R5 result count", 16'(qrd), 16'(qwr));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule